// File: doc/BRIEF.md
# Output-Compare Timer Channel

This block is one timer channel that produces a waveform on a single output pin. It has its own up-counter that advances on a slow channel tick. The channel tick comes from a prescaler, which divides the module clock-enable strobe by a programmable ratio. The channel holds two compare values, A and B. When the counter passes one of them, a match fires and moves the output flip-flop to a level chosen by a polarity bit. Match on B can then end a pulse that a match on A began, or the other way round.

Software reaches the channel through a plain register-write port. Address 0 is the control word. Addresses 1 and 2 hold the staging copies of A and B. Address 3 is a command strobe register.

The comparators never look at the staging copies. They use active copies, which take the staged values only when the counter rolls over. A period that is already running therefore keeps its compare points. A sticky event flag records real matches. It is sent either to an interrupt-request pin or to a trigger-request pin. A debug freeze input can stop the whole channel.

The write port is a register-access path and not a data stream, so it has no valid/ready handshake. Each write completes in the cycle it is presented.

Top module: `octc_channel`

## Requirements
- R1: After reset the counter, the prescaler, both active compare values, the control word and both staging values are 0. `cmp_out`, `flag`, `irq_req` and `trig_req` are all 0.
- R2: Control bit 0 (run) enables the prescaler, and control bits [4:1] hold the prescale value P. While run is 1 and the channel is not frozen, the counter advances once for every P+1 cycles in which `tick_en` is high. While run is 0, the counter and the prescaler hold their values.
- R3: The counter is `CNT_W` bits wide and counts upward. On a tick from its all-ones value it rolls over to 0.
- R4: A match on A happens when a tick occurs while the counter equals active A. A match on B is defined the same way with active B. On the clock edge of a match, `cmp_out` takes the polarity bit (control bit 5) for a match on A, and its inverse for a match on B. Without a match, `cmp_out` holds its value.
- R5: If events on A and on B occur at the same edge, whether real or forced, B wins and `cmp_out` takes the inverse of the polarity bit.
- R6: Writing address 3 with bit 0 set forces an A event, and with bit 1 set forces a B event. `cmp_out` changes at that edge exactly as it would for a real match. A forced event never sets `flag`.
- R7: Writes to address 1 or address 2 change only the staging copies. The active copies take the staged values, in their low `CNT_W` bits, only on the tick that rolls the counter over. Those are the values staged before that edge.
- R8: `flag` is set by a real match when flag-enable (control bit 6) is 1. It stays set until a write to address 3 with bit 2 set clears it. If a match and a clear happen at the same edge, the set wins.
- R9: Control bit 7 routes the flag. `irq_req` = flag AND flag-enable AND NOT bit 7. `trig_req` = flag AND flag-enable AND bit 7.
- R10: Freeze is active when control bit 8 is 1 and `freeze_in` is 1. During freeze the counter, the prescaler, the active values, `cmp_out` and `flag` hold, and commands written to address 3 are dropped. Writes to addresses 0, 1 and 2 still land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 stage A, 2 stage B, 3 command |
| wr_data | input | DATA_W | Write data |
| freeze_in | input | 1 | Global debug freeze request |
| tick_en | input | 1 | Clock-enable strobe that feeds the prescaler |
| cmp_out | output | 1 | Buffered compare output pin |
| flag | output | 1 | Sticky match flag |
| irq_req | output | 1 | Flag routed as an interrupt request |
| trig_req | output | 1 | Flag routed as a trigger request |

## Verification
Some behaviours are checked on every cycle. The counter holds while stopped and steps by one on each tick. The rollover lands on zero. The active values stay still except at rollover. The level after an A or B event is checked, including B's priority. The flag stays sticky, no event reaches the flag without a real match, freeze leaves the output and the flag untouched, and the two request pins are never high together.

Other behaviours need the bench's scenarios to show them. These are the exact tick spacing for each prescale value, and which staged value becomes active and in which period. The output waveform over whole periods needs them too, as do the combined effect of random stopping, freezing and reprogramming. For these the bench compares every output on every cycle against its own model.

// File: rtl/octc_pkg.sv
package octc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STGA = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_STGB = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CMD  = 2'd3;

  localparam int CMD_FORCE_A = 0;
  localparam int CMD_FORCE_B = 1;
  localparam int CMD_CLEAR   = 2;

  typedef struct packed {
    logic frz_en;
    logic route_trig;
    logic flag_en;
    logic pol;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/octc_regs.sv
module octc_regs
  import octc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              freeze_in,
  output ctrl_t             ctrl,
  output logic [PSC_W-1:0]  presc,
  output logic [DATA_W-1:0] stg_a,
  output logic [DATA_W-1:0] stg_b,
  output logic              frozen,
  output logic              force_a,
  output logic              force_b,
  output logic              clr_flag
);
  localparam int POL_BIT = PSC_W + 1;
  localparam int FEN_BIT = PSC_W + 2;
  localparam int RTE_BIT = PSC_W + 3;
  localparam int FRZ_BIT = PSC_W + 4;

  ctrl_t            ctrl_q;
  logic [PSC_W-1:0] presc_q;
  logic             cmd_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      stg_a   <= '0;
      stg_b   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          ctrl_q.run        <= wr_data[0];
          presc_q           <= wr_data[PSC_W:1];
          ctrl_q.pol        <= wr_data[POL_BIT];
          ctrl_q.flag_en    <= wr_data[FEN_BIT];
          ctrl_q.route_trig <= wr_data[RTE_BIT];
          ctrl_q.frz_en     <= wr_data[FRZ_BIT];
        end
        ADR_STGA: stg_a <= wr_data;
        ADR_STGB: stg_b <= wr_data;
        default: ;
      endcase
    end
  end

  assign ctrl   = ctrl_q;
  assign presc  = presc_q;
  assign frozen = ctrl_q.frz_en & freeze_in;
  // command strobes act at this edge and are dropped while frozen
  assign cmd_wr   = wr_en & (wr_addr == ADR_CMD) & ~frozen;
  assign force_a  = cmd_wr & wr_data[CMD_FORCE_A];
  assign force_b  = cmd_wr & wr_data[CMD_FORCE_B];
  assign clr_flag = cmd_wr & wr_data[CMD_CLEAR];

  // R1: control word returns to zero out of reset
  p_ctrl_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> (ctrl_q == '0 && presc_q == '0));
endmodule

// File: rtl/octc_timebase.sv
module octc_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             frozen,
  input  logic [PSC_W-1:0] presc,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step = run & tick_en & ~frozen;
  assign tick = step & (psc_q >= presc);
  assign wrap = tick & (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else begin
      if (step) psc_q <= tick ? '0 : psc_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

  // R2: a stopped channel keeps its count
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n) !run |=> $stable(cnt_q));
  // R2: each tick advances by exactly one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != CNT_MAX) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R3: rollover lands on zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> cnt_q == '0);
  // R10: frozen prescaler and counter stay put
  p_frz_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(cnt_q) && $stable(psc_q)));
endmodule

// File: rtl/octc_compare.sv
module octc_compare #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              tick,
  input  logic              wrap,
  input  logic              frozen,
  input  logic [DATA_W-1:0] stg_a,
  input  logic [DATA_W-1:0] stg_b,
  input  logic              pol,
  input  logic              flag_en,
  input  logic              force_a,
  input  logic              force_b,
  input  logic              clr_flag,
  output logic              out,
  output logic              flag
);
  logic [CNT_W-1:0] act_a, act_b;
  logic             hit_a, hit_b, ev_a, ev_b;
  logic             out_q, flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_a <= '0;
      act_b <= '0;
    end else if (wrap) begin
      act_a <= stg_a[CNT_W-1:0];
      act_b <= stg_b[CNT_W-1:0];
    end
  end

  assign hit_a = tick & (cnt == act_a);
  assign hit_b = tick & (cnt == act_b);
  assign ev_a  = hit_a | force_a;
  assign ev_b  = hit_b | force_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ev_b)      out_q <= ~pol;
      else if (ev_a) out_q <= pol;
      if ((hit_a | hit_b) & flag_en) flag_q <= 1'b1;
      else if (clr_flag)             flag_q <= 1'b0;
    end
  end

  assign out  = out_q;
  assign flag = flag_q;

  // R4: an A-only event leaves the polarity level on the pin
  p_a_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_a && !ev_b) |=> out_q == $past(pol));
  // R5: B wins whenever it fires
  p_b_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_b |=> out_q == !$past(pol));
  // R6: without a real match the flag cannot rise
  p_no_fake_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !hit_a && !hit_b) |=> !flag_q);
  // R7: active values move only on rollover
  p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_a) && $stable(act_b)));
  // R8: flag is sticky until cleared
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_flag) |=> flag_q);
  // R10: pin and flag hold during freeze
  p_frz_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(out_q) && $stable(flag_q)));
endmodule

// File: rtl/octc_channel.sv
module octc_channel
  import octc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int PSC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              freeze_in,
  input  logic              tick_en,
  output logic              cmp_out,
  output logic              flag,
  output logic              irq_req,
  output logic              trig_req
);
  ctrl_t             ctrl;
  logic [PSC_W-1:0]  presc;
  logic [DATA_W-1:0] stg_a, stg_b;
  logic              frozen, force_a, force_b, clr_flag;
  logic [CNT_W-1:0]  cnt;
  logic              tick, wrap;

  octc_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freeze_in(freeze_in), .ctrl(ctrl), .presc(presc), .stg_a(stg_a), .stg_b(stg_b),
    .frozen(frozen), .force_a(force_a), .force_b(force_b), .clr_flag(clr_flag));

  octc_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick_en(tick_en), .frozen(frozen),
    .presc(presc), .cnt(cnt), .tick(tick), .wrap(wrap));

  octc_compare #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .tick(tick), .wrap(wrap), .frozen(frozen),
    .stg_a(stg_a), .stg_b(stg_b), .pol(ctrl.pol), .flag_en(ctrl.flag_en),
    .force_a(force_a), .force_b(force_b), .clr_flag(clr_flag),
    .out(cmp_out), .flag(flag));

  assign irq_req  = flag & ctrl.flag_en & ~ctrl.route_trig;
  assign trig_req = flag & ctrl.flag_en &  ctrl.route_trig;

  // R9: one destination at a time
  p_one_route_r9: assert property (@(posedge clk) disable iff (!rst_n) !(irq_req && trig_req));
endmodule

// File: tb/octc_channel_tb.sv
`timescale 1ns/1ps
module octc_channel_tb;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 16;
  localparam int PSC_W  = 4;
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, freeze_in = 1'b0, tick_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic cmp_out, flag, irq_req, trig_req;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 1'b0, done = 1'b0;
  string lbl = "R1";

  always #2 clk = ~clk;

  octc_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W), .PSC_W(PSC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freeze_in(freeze_in), .tick_en(tick_en), .cmp_out(cmp_out), .flag(flag),
    .irq_req(irq_req), .trig_req(trig_req));

  // bench model of the requirements
  logic [DATA_W-1:0] m_ctrl, m_sa, m_sb;
  logic [CNT_W-1:0]  m_aa, m_ab, m_cnt;
  logic [PSC_W-1:0]  m_psc;
  logic m_out, m_flag;
  logic fz, st, tk, wp, ha, hb, fa, fb, cl, cmdw;

  function automatic logic exp_irq(logic [DATA_W-1:0] c, logic f);
    return f & c[6] & ~c[7];
  endfunction
  function automatic logic exp_trig(logic [DATA_W-1:0] c, logic f);
    return f & c[6] & c[7];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_sa = '0; m_sb = '0; m_aa = '0; m_ab = '0;
      m_cnt = '0; m_psc = '0; m_out = 1'b0; m_flag = 1'b0;
    end else begin
      fz   = m_ctrl[8] & freeze_in;
      st   = m_ctrl[0] & tick_en & ~fz;
      tk   = st & (m_psc >= m_ctrl[4:1]);
      wp   = tk & (m_cnt == MAXC);
      ha   = tk & (m_cnt == m_aa);
      hb   = tk & (m_cnt == m_ab);
      cmdw = wr_en & (wr_addr == 2'd3) & ~fz;
      fa   = cmdw & wr_data[0];
      fb   = cmdw & wr_data[1];
      cl   = cmdw & wr_data[2];
      if (hb | fb)      m_out = ~m_ctrl[5];
      else if (ha | fa) m_out = m_ctrl[5];
      if ((ha | hb) & m_ctrl[6]) m_flag = 1'b1;
      else if (cl)               m_flag = 1'b0;
      if (wp) begin m_aa = m_sa[CNT_W-1:0]; m_ab = m_sb[CNT_W-1:0]; end
      if (st) m_psc = tk ? '0 : m_psc + 1'b1;
      if (tk) m_cnt = m_cnt + 1'b1;
      if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data;
      if (wr_en && wr_addr == 2'd1) m_sa = wr_data;
      if (wr_en && wr_addr == 2'd2) m_sb = wr_data;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, tagged with the current scenario
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      check(lbl, "cmp_out (R4)", cmp_out, m_out);
      check(lbl, "flag (R8)", flag, m_flag);
      check(lbl, "irq_req (R9)", irq_req, exp_irq(m_ctrl, m_flag));
      check(lbl, "trig_req (R9)", trig_req, exp_trig(m_ctrl, m_flag));
    end
  end

  task automatic wr(logic [1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rand_cycle(int wr_pct, bit ctrl_ok, bit cmd_ok, int frz_pct, int tk_pct);
    logic [1:0] a;
    @(negedge clk);
    tick_en   = ($urandom % 100) < tk_pct;
    freeze_in = ($urandom % 100) < frz_pct;
    wr_en     = 1'b0;
    if (($urandom % 100) < wr_pct) begin
      a = 2'($urandom % 4);
      if (a == 2'd0 && !ctrl_ok) a = 2'd1;
      if (a == 2'd3 && !cmd_ok)  a = 2'd2;
      wr_en = 1'b1; wr_addr = a;
      case (a)
        2'd0: wr_data = {7'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                         2'b00, 2'($urandom), ($urandom % 8) != 0};
        2'd3: wr_data = {13'b0, 3'($urandom)};
        default: wr_data = DATA_W'($urandom);
      endcase
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1", "cmp_out", cmp_out, 1'b0);
    check("R1", "flag", flag, 1'b0);
    check("R1", "irq_req", irq_req, 1'b0);
    check("R1", "trig_req", trig_req, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R6: forced events with polarity 1, counter stopped
    lbl = "R6";
    wr(2'd0, 16'h0060);
    wr(2'd3, 16'h0001);
    check("R6", "cmp_out after force A", cmp_out, 1'b1);
    check("R6", "flag after force A", flag, 1'b0);
    wr(2'd3, 16'h0002);
    check("R6", "cmp_out after force B", cmp_out, 1'b0);
    check("R6", "flag after force B", flag, 1'b0);

    // R5: simultaneous A and B events
    lbl = "R5";
    wr(2'd3, 16'h0001);
    wr(2'd3, 16'h0003);
    check("R5", "cmp_out after A+B", cmp_out, 1'b0);

    // R10: freeze drops commands but still takes staging writes
    lbl = "R10";
    wr(2'd0, 16'h0120);
    freeze_in = 1'b1;
    wr(2'd3, 16'h0001);
    check("R10", "cmp_out frozen force", cmp_out, 1'b0);
    wr(2'd1, 16'h0007);
    freeze_in = 1'b0;

    // R8 / R9: real match at count 0 with actives at 0, then clear
    lbl = "R8";
    tick_en = 1'b1;
    wr(2'd0, 16'h0061);
    @(negedge clk);
    check("R8", "flag after real match", flag, 1'b1);
    check("R9", "irq_req routed", irq_req, 1'b1);
    check("R9", "trig_req routed", trig_req, 1'b0);
    check("R5", "cmp_out both matched", cmp_out, 1'b0);
    wr(2'd3, 16'h0004);
    check("R8", "flag after clear", flag, 1'b0);
    tick_en = 1'b0;

    // R2: random run/stop and prescale with sparse ticks
    lbl = "R2";
    repeat (4000) rand_cycle(5, 1'b1, 1'b0, 0, 60);

    // R3 and R7: free running, restaging A and B across many rollovers
    lbl = "R7";
    wr(2'd0, 16'h0041);
    repeat (6000) rand_cycle(3, 1'b0, 1'b0, 0, 100);
    lbl = "R3";
    wr(2'd0, 16'h00C1);
    repeat (3000) rand_cycle(2, 1'b0, 1'b1, 0, 100);

    // R4 / R10: everything random, including freeze and commands
    lbl = "R4";
    repeat (15000) rand_cycle(6, 1'b1, 1'b1, 15, 80);
    lbl = "R10";
    wr(2'd0, 16'h0161);
    repeat (3000) rand_cycle(6, 1'b0, 1'b1, 40, 100);

    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule